// File: doc/BRIEF.md
# GPIO Controller with Per-Line Edge Interrupts

A sixteen-line general-purpose I/O block behind a plain register port (address, write strobe, write data, combinational read data). Every line is configured on its own as an input or an output. Output lines drive the value held in an output-data register. Input lines pass through a two-stage synchronizer. Their synchronized levels can be read back, and each one can raise an interrupt on a single selected edge, either rising or falling.

A detected edge on an armed line sets a sticky status bit. A line is armed when it is an input and its mask bit is clear. Software clears status bits by writing ones to them. A single interrupt output is high while any status bit is set. Output data is stored in full whatever the direction, so software can preload a value before it turns a line into an output.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, reads return 0x0000 for data input (offset 0x00) and status (0x14), and 0xFFFF for data output (0x04), direction (0x08), edge select (0x0C) and mask (0x10). irq_o, pin_oe_o and pin_o are all 0.
- R2: A write to offset 0x04, 0x08, 0x0C or 0x10 stores bits [15:0] of the write data. A read returns the stored value with bits [31:16] zero.
- R3: Offset 0x00 is read-only, and a write to it has no effect. A read of it returns the synchronized pin levels.
- R4: Direction bit 1 makes a line an input: pin_oe_o is 0 and pin_o is 0. Direction bit 0 makes it an output: pin_oe_o is 1 and pin_o equals the stored output-data bit.
- R5: Output data written while a line is an input is kept. When that line is later switched to an output, pin_o shows the kept value.
- R6: Edge-select bit 1 makes only a 0-to-1 transition of the synchronized input an event. Bit 0 makes only a 1-to-0 transition an event.
- R7: An event sets its status bit only when the line's direction bit is 1 and its mask bit is 0.
- R8: A write to the status offset 0x14 clears each status bit written as 1 and leaves bits written as 0 unchanged.
- R9: irq_o is 1 exactly when at least one status bit is set.
- R10: If an event and a write-one-to-clear reach the same status bit in the same cycle, the bit stays set.
- R11: Within the 4 KB window, any offset other than the six listed reads as 0, and a write to it changes no register.
- R12: A pin change that happens before clock edge k shows up in the data-input register after edge k+1 and in the status register after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 12 | Byte offset within the register window |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| pin_i | input | 16 | Pin input levels, asynchronous |
| pin_o | output | 16 | Pin output values |
| pin_oe_o | output | 16 | Pin output enables, 1 drives the pin |
| irq_o | output | 1 | Combined interrupt |

## Verification
Two functions can act on the same status bit in one cycle: a new edge event setting it and a software write-one-to-clear. The bench first sets a status bit with a rising edge, lowers the pin, and then raises it again. It times a clear of that bit and of a second, idle bit so that the write commits on the same clock edge as the new event. The event bit is then expected to read as set and the idle bit as cleared. A bound property also checks that every event survives into the next cycle, whatever is written.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned OFS_W = 12;
  localparam logic [OFS_W-1:0] OFS_DIN  = 12'h000;
  localparam logic [OFS_W-1:0] OFS_DOUT = 12'h004;
  localparam logic [OFS_W-1:0] OFS_DIR  = 12'h008;
  localparam logic [OFS_W-1:0] OFS_EDGE = 12'h00C;
  localparam logic [OFS_W-1:0] OFS_MASK = 12'h010;
  localparam logic [OFS_W-1:0] OFS_STS  = 12'h014;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_pkg::*;
#(
  parameter int unsigned N  = 16,
  parameter int unsigned DW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [OFS_W-1:0] addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [N-1:0]     dout_o,
  output logic [N-1:0]     dir_o,
  output logic [N-1:0]     edge_o,
  output logic [N-1:0]     mask_o
);
  logic [N-1:0] wval;
  assign wval = wdata_i[N-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_o <= '1;
      dir_o  <= '1;
      edge_o <= '1;
      mask_o <= '1;
    end else if (we_i) begin
      unique case (addr_i)
        OFS_DOUT: dout_o <= wval;
        OFS_DIR:  dir_o  <= wval;
        OFS_EDGE: edge_o <= wval;
        OFS_MASK: mask_o <= wval;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int unsigned N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] dir_i,
  input  logic [N-1:0] edge_i,
  input  logic [N-1:0] mask_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] evt_o,
  output logic [N-1:0] sts_o,
  output logic         irq_o
);
  logic [N-1:0] prev_q, rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  assign rise  = lvl_i & ~prev_q;
  assign fall  = ~lvl_i & prev_q;
  assign evt_o = ((edge_i & rise) | (~edge_i & fall)) & dir_i & ~mask_i;

  // a new event takes priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_o <= '0;
    else         sts_o <= (sts_o & ~clr_i) | evt_o;
  end

  assign irq_o = |sts_o;
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_pkg::*;
#(
  parameter int unsigned N_LINES = 16,
  parameter int unsigned DATA_W  = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [OFS_W-1:0]    addr_i,
  input  logic                we_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [N_LINES-1:0]  pin_i,
  output logic [N_LINES-1:0]  pin_o,
  output logic [N_LINES-1:0]  pin_oe_o,
  output logic                irq_o
);
  localparam int unsigned PAD_W = DATA_W - N_LINES;

  logic [N_LINES-1:0] din, dout_q, dir_q, edge_q, mask_q, sts_q, evt, clr;
  logic [N_LINES-1:0] rsel;

  gpio_sync #(.N(N_LINES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (din)
  );

  gpio_regfile #(.N(N_LINES), .DW(DATA_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .dout_o (dout_q),
    .dir_o  (dir_q),
    .edge_o (edge_q),
    .mask_o (mask_q)
  );

  assign clr = (we_i && addr_i == OFS_STS) ? wdata_i[N_LINES-1:0] : '0;

  gpio_irq_status #(.N(N_LINES)) u_sts (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (din),
    .dir_i (dir_q),
    .edge_i(edge_q),
    .mask_i(mask_q),
    .clr_i (clr),
    .evt_o (evt),
    .sts_o (sts_q),
    .irq_o (irq_o)
  );

  assign pin_oe_o = ~dir_q;
  assign pin_o    = dout_q & ~dir_q;

  always_comb begin
    unique case (addr_i)
      OFS_DIN:  rsel = din;
      OFS_DOUT: rsel = dout_q;
      OFS_DIR:  rsel = dir_q;
      OFS_EDGE: rsel = edge_q;
      OFS_MASK: rsel = mask_q;
      OFS_STS:  rsel = sts_q;
      default:  rsel = '0;
    endcase
  end
  assign rdata_o = {{PAD_W{1'b0}}, rsel};
endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk
  import gpio_pkg::*;
#(
  parameter int unsigned N  = 16,
  parameter int unsigned DW = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic [OFS_W-1:0] addr_i,
  input logic [DW-1:0]    wdata_i,
  input logic [N-1:0]     pin_oe_o,
  input logic             irq_o,
  input logic [N-1:0]     sts_q,
  input logic [N-1:0]     evt,
  input logic [N-1:0]     dir_q,
  input logic [N-1:0]     mask_q
);
  logic sts_wr;
  assign sts_wr = we_i && (addr_i == OFS_STS);

  AST_DIR_DRIVES_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFS_DIR) |=> (pin_oe_o == ~$past(wdata_i[N-1:0]))); // R4

  AST_NEW_BITS_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sts_q & ~$past(sts_q) & ($past(mask_q) | ~$past(dir_q))) == '0)); // R7

  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_wr && evt == '0) |=> ((sts_q & $past(wdata_i[N-1:0])) == '0)); // R8

  AST_IRQ_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !sts_wr) |=> irq_o); // R9

  AST_EVENT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt != '0) |=> ((sts_q & $past(evt)) == $past(evt))); // R10
endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.N(N_LINES), .DW(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .pin_oe_o(pin_oe_o),
  .irq_o   (irq_o),
  .sts_q   (sts_q),
  .evt     (evt),
  .dir_q   (dir_q),
  .mask_q  (mask_q)
);

// File: tb/sim_gpio_edge_irq.sv
`timescale 1ns/1ps
module sim_gpio_edge_irq;
  localparam int K_RD = 0, K_IRQ = 1, K_PIN = 2, K_OE = 3;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [15:0] pin_i = '0;
  logic [15:0] pin_o, pin_oe_o;
  logic        irq_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  item_t sb_q[$];

  always #4 clk_i = ~clk_i;

  gpio_edge_irq u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pin_i(pin_i), .pin_o(pin_o),
    .pin_oe_o(pin_oe_o), .irq_o(irq_o)
  );

  task automatic step();
    @(posedge clk_i); #1;
    we_i = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    step();
    addr_i = a; wdata_i = d; we_i = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic set_pins(input logic [15:0] v);
    step();
    pin_i = v;
  endtask

  task automatic expect_item(input int k, input logic [11:0] a,
                             input logic [31:0] e, input string t);
    item_t it;
    step();
    if (k == K_RD) addr_i = a;
    it.kind = k; it.exp = e; it.tag = t;
    sb_q.push_back(it);
  endtask

  // monitor: compares half a cycle after the driver, away from the edge
  initial begin
    forever begin
      @(negedge clk_i);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb_q.pop_front();
        case (it.kind)
          K_RD:    act = rdata_o;
          K_IRQ:   act = {31'b0, irq_o};
          K_PIN:   act = {16'b0, pin_o};
          default: act = {16'b0, pin_oe_o};
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual 0x%0h expected 0x%0h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    expect_item(K_RD, 12'h000, 32'h0, "R1 din");
    expect_item(K_RD, 12'h004, 32'hFFFF, "R1 dout");
    expect_item(K_RD, 12'h008, 32'hFFFF, "R1 dir");
    expect_item(K_RD, 12'h00C, 32'hFFFF, "R1 edge");
    expect_item(K_RD, 12'h010, 32'hFFFF, "R1 mask");
    expect_item(K_RD, 12'h014, 32'h0, "R1 status");
    expect_item(K_IRQ, 0, 32'h0, "R1 irq");
    expect_item(K_OE, 0, 32'h0, "R1 oe");
    expect_item(K_PIN, 0, 32'h0, "R1 pin");

    wr(12'h00C, 32'hFFFF_A5A5);
    expect_item(K_RD, 12'h00C, 32'hA5A5, "R2 edge readback");
    wr(12'h00C, 32'h0000_0F00);
    wr(12'h010, 32'h0000_8000);
    expect_item(K_RD, 12'h010, 32'h8000, "R2 mask readback");

    wr(12'h018, 32'h1234);
    wr(12'hFFC, 32'h0);
    expect_item(K_RD, 12'h018, 32'h0, "R11 unmapped read");
    expect_item(K_RD, 12'h00C, 32'h0F00, "R11 edge untouched");
    expect_item(K_RD, 12'h010, 32'h8000, "R11 mask untouched");

    wr(12'h000, 32'h5555);
    expect_item(K_RD, 12'h000, 32'h0, "R3 din write ignored");

    wr(12'h004, 32'h1234);
    expect_item(K_RD, 12'h004, 32'h1234, "R5 dout kept for inputs");
    expect_item(K_PIN, 0, 32'h0, "R4 input lines not driven");
    wr(12'h008, 32'hFF00);
    expect_item(K_OE, 0, 32'h00FF, "R4 oe follows dir");
    expect_item(K_PIN, 0, 32'h0034, "R4 pin gated by dir");

    // lines 8-11 rising, 12-15 falling, 15 masked; line 0 is an output (R7)
    set_pins(16'hFF01);
    expect_item(K_RD, 12'h000, 32'h0, "R12 din not yet");
    expect_item(K_IRQ, 0, 32'h0, "R12 irq not yet");
    expect_item(K_RD, 12'h014, 32'h0F00, "R6 rising lines only");
    expect_item(K_IRQ, 0, 32'h1, "R9 irq set");
    expect_item(K_RD, 12'h000, 32'hFF01, "R3 din synced");

    set_pins(16'h0001);
    idle(2);
    expect_item(K_RD, 12'h014, 32'h7F00, "R7 masked line blocked, R6 falling");

    wr(12'h014, 32'h0300);
    expect_item(K_RD, 12'h014, 32'h7C00, "R8 partial clear");
    wr(12'h014, 32'h7C00);
    expect_item(K_RD, 12'h014, 32'h0, "R8 full clear");
    expect_item(K_IRQ, 0, 32'h0, "R9 irq drops");

    // R10: set bit 9 again, lower line 8, raise it with a clear on the same edge
    set_pins(16'h0301);
    idle(2);
    set_pins(16'h0201);
    idle(2);
    set_pins(16'h0301);
    idle(1);
    wr(12'h014, 32'h0300);
    expect_item(K_RD, 12'h014, 32'h0100, "R10 event beats clear");
    wr(12'h014, 32'hFFFF);
    expect_item(K_IRQ, 0, 32'h0, "R9 irq clear after all");

    wr(12'h008, 32'h0000);
    expect_item(K_PIN, 0, 32'h1234, "R5 stored value appears");
    expect_item(K_OE, 0, 32'hFFFF, "R4 all outputs");
    wr(12'h008, 32'hFFFF);
    expect_item(K_PIN, 0, 32'h0, "R4 back to inputs");
    idle(2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule